// File: doc/BRIEF.md
# Split Exponent/Mantissa Arithmetic Unit

This execution unit holds floating-point operands as two separate parts: an exponent register file and a mantissa register file. It does not run fused floating-point add or multiply. It runs primitive steps on each part instead. These steps are exponent add and subtract, a leading-zero count that gives the left shift needed to normalize a mantissa, and raw mantissa add, subtract and multiply with no normalization or rounding. It also provides shifts in both directions driven by a signed count, sign clear and sign flip, and two condition tests: a relational compare of exponent/mantissa pairs and an exponent sign test.

A compiler that targets this unit can schedule alignment and normalization as ordinary operations. It can then drop the shifts that a fused unit would repeat between dependent operations. Mantissas are sign-magnitude: one sign bit above a 27-bit magnitude, made of 24 fraction bits and 3 guard bits on the right. The magnitude is read as a fraction in [0,1), so a normalized value has bit 26 set. Exponents are 10-bit two's complement. Two immediate-load operations fill the register files.

One instruction issues per cycle. Its result appears on the writeback or condition outputs one clock after valid. The target register is updated on that same edge, so the next instruction reads the new value.

Top module: `sxm_unit`

## Requirements
- R1: The effect of an instruction accepted with `in_valid` high appears on the outputs exactly one clock later. At most one of `e_wr_en`, `m_wr_en`, `cond_valid` is high, and none is high after a cycle with `in_valid` low or with an opcode of 14 or 15. A written register is read correctly by an instruction issued in the very next cycle.
- R2: Opcode 0 writes `in_imm[9:0]` to exponent register `in_dst`. Opcode 1 writes `in_imm[27:0]` to mantissa register `in_dst`.
- R3: Opcodes 2 and 3 write E[a]+E[b] and E[a]-E[b] into E[dst], modulo 2^10.
- R4: Opcode 4 writes into E[dst] the number of leading zeros of the 27-bit magnitude of M[a]. A zero magnitude gives 27.
- R5: Opcodes 5 and 6 write the sign-magnitude sum M[a]+M[b] and difference M[a]-M[b] into M[dst]. A carry out of bit 26 is dropped. A zero result magnitude always has sign 0.
- R6: Opcode 7 writes into M[dst] bits 53..27 of the 54-bit product of the magnitudes, with sign equal to the XOR of the signs (sign 0 when the magnitude is zero). The product of two normalized mantissas therefore has bit 26 or bit 25 set.
- R7: Opcode 8 shifts the magnitude of M[a] left and opcode 9 shifts it right, by the signed count in E[b]. A negative count shifts the other way by its absolute value. The sign bit is kept.
- R8: A shift whose count has an absolute value of 27 or more gives a zero magnitude.
- R9: Opcode 10 writes M[a] with bit 27 cleared into M[dst]. Opcode 11 writes M[a] with bit 27 inverted.
- R10: Opcode 12 sets `cond` to the relation `in_rel` of (E[a],M[a]) against (E[b],M[b]). The `in_rel` codes are 0 EQ, 1 NE, 2 LT, 3 LE, 4 GT, 5 GE; 6 and 7 always give 0. A zero magnitude is zero, whatever its sign and exponent. Zero ranks above every negative and below every positive. Two positives are ordered by signed exponent and then by magnitude. Two negatives are ordered the reverse way.
- R11: Opcode 13 sets `cond` to the sign bit of E[a].
- R12: While `rst_n` is low all outputs are 0 and every register of both files is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode |
| in_rel | input | 3 | Relational code for the compare |
| in_dst | input | 3 | Destination register index |
| in_a | input | 3 | First source register index |
| in_b | input | 3 | Second source register index |
| in_imm | input | 28 | Immediate for the load operations |
| e_wr_en | output | 1 | Exponent writeback valid |
| e_wr_idx | output | 3 | Exponent register written |
| e_wr_data | output | 10 | Exponent value written |
| m_wr_en | output | 1 | Mantissa writeback valid |
| m_wr_idx | output | 3 | Mantissa register written |
| m_wr_data | output | 28 | Mantissa value written (bit 27 sign) |
| cond_valid | output | 1 | Condition result valid |
| cond | output | 1 | Condition result |

## Verification
A result is written back and a dependent instruction reads that same register in the cycle right after. The bench provokes this by holding `in_valid` high across consecutive issues: an immediate load followed at once by an add of the freshly loaded register to itself, and an exponent load followed at once by a shift that uses it as a count. In the first of those cycles the bench checks that the writeback output shows the load. In the second it checks that the result was computed from the new value rather than the cleared reset value.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
    typedef enum logic [3:0] {
        OP_ELDI = 4'd0,
        OP_MLDI = 4'd1,
        OP_EADD = 4'd2,
        OP_ESUB = 4'd3,
        OP_FFO  = 4'd4,
        OP_MADD = 4'd5,
        OP_MSUB = 4'd6,
        OP_MMUL = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ABS  = 4'd10,
        OP_NEG  = 4'd11,
        OP_CMP  = 4'd12,
        OP_ENEG = 4'd13
    } op_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5
    } rel_e;
endpackage

// File: rtl/sxm_expo.sv
module sxm_expo #(
    parameter int EXP_W = 10,
    parameter int MAG_W = 27
) (
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    input  logic             sub,
    input  logic [MAG_W-1:0] mag,
    output logic [EXP_W-1:0] sum,
    output logic [EXP_W-1:0] lead
);
    localparam int CNT_W = $clog2(MAG_W + 1);

    logic [CNT_W-1:0] lz;

    assign sum = sub ? (ea - eb) : (ea + eb);

    // ascending scan: the highest set bit is the last to assign
    always_comb begin
        lz = CNT_W'(MAG_W);
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) lz = CNT_W'(MAG_W - 1 - i);
        end
    end

    assign lead = EXP_W'(lz);
endmodule

// File: rtl/sxm_mant_alu.sv
module sxm_mant_alu #(
    parameter int MAG_W = 27
) (
    input  logic [MAG_W:0] ma,
    input  logic [MAG_W:0] mb,
    input  logic           sub,
    output logic [MAG_W:0] addsub,
    output logic [MAG_W:0] prod
);
    localparam int PRD_W = 2 * MAG_W;

    logic             sa, sb;
    logic [MAG_W-1:0] am, bm, rm;
    logic             rs;
    logic [PRD_W-1:0] full;
    logic [MAG_W-1:0] pm;

    assign sa = ma[MAG_W];
    assign sb = mb[MAG_W] ^ sub;
    assign am = ma[MAG_W-1:0];
    assign bm = mb[MAG_W-1:0];

    always_comb begin
        if (sa == sb) begin
            rm = am + bm;
            rs = sa;
        end else if (am >= bm) begin
            rm = am - bm;
            rs = sa;
        end else begin
            rm = bm - am;
            rs = sb;
        end
        addsub = {rs & (rm != '0), rm};
    end

    assign full = PRD_W'(am) * PRD_W'(bm);
    assign pm   = full[PRD_W-1:MAG_W];
    assign prod = {(ma[MAG_W] ^ mb[MAG_W]) & (pm != '0), pm};
endmodule

// File: rtl/sxm_shift.sv
module sxm_shift #(
    parameter int EXP_W = 10,
    parameter int MAG_W = 27
) (
    input  logic [MAG_W-1:0] mag,
    input  logic [EXP_W-1:0] count,
    input  logic             left,
    output logic [MAG_W-1:0] res
);
    logic signed [EXP_W:0] cx;
    logic        [EXP_W:0] amt;
    logic                  go_left;

    assign cx      = {count[EXP_W-1], count};
    assign amt     = cx[EXP_W] ? (EXP_W+1)'(-cx) : (EXP_W+1)'(cx);
    assign go_left = left ^ count[EXP_W-1];

    always_comb begin
        if (amt >= (EXP_W+1)'(MAG_W)) res = '0;
        else if (go_left)             res = mag << amt;
        else                          res = mag >> amt;
    end
endmodule

// File: rtl/sxm_cmp.sv
module sxm_cmp #(
    parameter int EXP_W = 10,
    parameter int MAG_W = 27
) (
    input  logic [EXP_W-1:0] ea,
    input  logic [EXP_W-1:0] eb,
    input  logic [MAG_W:0]   ma,
    input  logic [MAG_W:0]   mb,
    input  logic [2:0]       rel,
    output logic             hit
);
    import sxm_pkg::*;

    logic za, zb, na, nb;
    logic key_gt, key_eq;
    logic lt, eq, gt;

    assign za = (ma[MAG_W-1:0] == '0);
    assign zb = (mb[MAG_W-1:0] == '0);
    assign na = ma[MAG_W] & ~za;
    assign nb = mb[MAG_W] & ~zb;

    assign key_gt = ($signed(ea) > $signed(eb)) ||
                    ((ea == eb) && (ma[MAG_W-1:0] > mb[MAG_W-1:0]));
    assign key_eq = (ea == eb) && (ma[MAG_W-1:0] == mb[MAG_W-1:0]);

    always_comb begin
        if (za && zb) begin
            eq = 1'b1; gt = 1'b0;
        end else if (za) begin
            eq = 1'b0; gt = nb;
        end else if (zb) begin
            eq = 1'b0; gt = ~na;
        end else if (na != nb) begin
            eq = 1'b0; gt = nb;
        end else begin
            eq = key_eq;
            gt = na ? (~key_gt & ~key_eq) : key_gt;
        end
        lt = ~eq & ~gt;
    end

    always_comb begin
        case (rel_e'(rel))
            REL_EQ:  hit = eq;
            REL_NE:  hit = ~eq;
            REL_LT:  hit = lt;
            REL_LE:  hit = lt | eq;
            REL_GT:  hit = gt;
            REL_GE:  hit = gt | eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sxm_unit.sv
module sxm_unit #(
    parameter int EXP_W  = 10,
    parameter int FRAC_W = 24,
    parameter int GRD_W  = 3,
    parameter int NREG   = 8,
    localparam int MAG_W = FRAC_W + GRD_W,
    localparam int MNT_W = MAG_W + 1,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [2:0]       in_rel,
    input  logic [IDX_W-1:0] in_dst,
    input  logic [IDX_W-1:0] in_a,
    input  logic [IDX_W-1:0] in_b,
    input  logic [MNT_W-1:0] in_imm,
    output logic             e_wr_en,
    output logic [IDX_W-1:0] e_wr_idx,
    output logic [EXP_W-1:0] e_wr_data,
    output logic             m_wr_en,
    output logic [IDX_W-1:0] m_wr_idx,
    output logic [MNT_W-1:0] m_wr_data,
    output logic             cond_valid,
    output logic             cond
);
    import sxm_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][EXP_W-1:0] erf;
        logic [NREG-1:0][MNT_W-1:0] mrf;
        logic                       e_en;
        logic [IDX_W-1:0]           e_idx;
        logic [EXP_W-1:0]           e_dat;
        logic                       m_en;
        logic [IDX_W-1:0]           m_idx;
        logic [MNT_W-1:0]           m_dat;
        logic                       c_vld;
        logic                       c_bit;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [EXP_W-1:0] ea, eb, e_sum, e_lead;
    logic [MNT_W-1:0] ma, mb, m_addsub, m_prod;
    logic [MAG_W-1:0] m_shift;
    logic             cmp_hit;

    assign op = op_e'(in_op);
    assign ea = st_q.erf[in_a];
    assign eb = st_q.erf[in_b];
    assign ma = st_q.mrf[in_a];
    assign mb = st_q.mrf[in_b];

    sxm_expo #(.EXP_W(EXP_W), .MAG_W(MAG_W)) u_expo (
        .ea   (ea),
        .eb   (eb),
        .sub  (op == OP_ESUB),
        .mag  (ma[MAG_W-1:0]),
        .sum  (e_sum),
        .lead (e_lead)
    );

    sxm_mant_alu #(.MAG_W(MAG_W)) u_malu (
        .ma     (ma),
        .mb     (mb),
        .sub    (op == OP_MSUB),
        .addsub (m_addsub),
        .prod   (m_prod)
    );

    sxm_shift #(.EXP_W(EXP_W), .MAG_W(MAG_W)) u_shift (
        .mag   (ma[MAG_W-1:0]),
        .count (eb),
        .left  (op == OP_SHL),
        .res   (m_shift)
    );

    sxm_cmp #(.EXP_W(EXP_W), .MAG_W(MAG_W)) u_cmp (
        .ea  (ea),
        .eb  (eb),
        .ma  (ma),
        .mb  (mb),
        .rel (in_rel),
        .hit (cmp_hit)
    );

    always_comb begin
        logic             e_we, m_we;
        logic [EXP_W-1:0] e_val;
        logic [MNT_W-1:0] m_val;
        st_d       = st_q;
        st_d.e_en  = 1'b0;
        st_d.m_en  = 1'b0;
        st_d.c_vld = 1'b0;
        e_we  = 1'b0;
        m_we  = 1'b0;
        e_val = '0;
        m_val = '0;
        if (in_valid) begin
            case (op)
                OP_ELDI: begin e_we = 1'b1; e_val = in_imm[EXP_W-1:0]; end
                OP_EADD,
                OP_ESUB: begin e_we = 1'b1; e_val = e_sum; end
                OP_FFO:  begin e_we = 1'b1; e_val = e_lead; end
                OP_MLDI: begin m_we = 1'b1; m_val = in_imm; end
                OP_MADD,
                OP_MSUB: begin m_we = 1'b1; m_val = m_addsub; end
                OP_MMUL: begin m_we = 1'b1; m_val = m_prod; end
                OP_SHL,
                OP_SHR:  begin m_we = 1'b1; m_val = {ma[MAG_W], m_shift}; end
                OP_ABS:  begin m_we = 1'b1; m_val = {1'b0, ma[MAG_W-1:0]}; end
                OP_NEG:  begin m_we = 1'b1; m_val = {~ma[MAG_W], ma[MAG_W-1:0]}; end
                OP_CMP:  begin st_d.c_vld = 1'b1; st_d.c_bit = cmp_hit; end
                OP_ENEG: begin st_d.c_vld = 1'b1; st_d.c_bit = ea[EXP_W-1]; end
                default: ;
            endcase
        end
        if (e_we) begin
            st_d.e_en         = 1'b1;
            st_d.e_idx        = in_dst;
            st_d.e_dat        = e_val;
            st_d.erf[in_dst]  = e_val;
        end
        if (m_we) begin
            st_d.m_en         = 1'b1;
            st_d.m_idx        = in_dst;
            st_d.m_dat        = m_val;
            st_d.mrf[in_dst]  = m_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign e_wr_en    = st_q.e_en;
    assign e_wr_idx   = st_q.e_idx;
    assign e_wr_data  = st_q.e_dat;
    assign m_wr_en    = st_q.m_en;
    assign m_wr_idx   = st_q.m_idx;
    assign m_wr_data  = st_q.m_dat;
    assign cond_valid = st_q.c_vld;
    assign cond       = st_q.c_bit;
endmodule

// File: rtl/sxm_unit_chk.sv
module sxm_unit_chk #(
    parameter int EXP_W = 10,
    parameter int MAG_W = 27,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [IDX_W-1:0] in_dst,
    input logic [MAG_W:0]   in_imm,
    input logic             e_wr_en,
    input logic [IDX_W-1:0] e_wr_idx,
    input logic [EXP_W-1:0] e_wr_data,
    input logic             m_wr_en,
    input logic [IDX_W-1:0] m_wr_idx,
    input logic [MAG_W:0]   m_wr_data,
    input logic             cond_valid
);
    import sxm_pkg::*;

    // R1
    wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({e_wr_en, m_wr_en, cond_valid}));

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(e_wr_en || m_wr_en || cond_valid));

    // R2
    eldi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'(OP_ELDI)) |=>
        (e_wr_en && e_wr_idx == $past(in_dst) && e_wr_data == $past(in_imm[EXP_W-1:0])));

    // R2
    mldi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'(OP_MLDI)) |=>
        (m_wr_en && m_wr_idx == $past(in_dst) && m_wr_data == $past(in_imm)));

    // R4
    ffo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'(OP_FFO)) |=> (e_wr_en && e_wr_data <= EXP_W'(MAG_W)));

    // R9
    abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'(OP_ABS)) |=> (m_wr_en && !m_wr_data[MAG_W]));

    // R10
    cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'(OP_CMP) || in_op == 4'(OP_ENEG))) |=> cond_valid);

    // R12
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> !(e_wr_en || m_wr_en || cond_valid));
endmodule

bind sxm_unit sxm_unit_chk #(.EXP_W(EXP_W), .MAG_W(MAG_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sxm_unit_tb.sv
module sxm_unit_tb;
    import sxm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [2:0]  in_rel = '0;
    logic [2:0]  in_dst = '0, in_a = '0, in_b = '0;
    logic [27:0] in_imm = '0;
    logic        e_wr_en, m_wr_en, cond_valid, cond;
    logic [2:0]  e_wr_idx, m_wr_idx;
    logic [9:0]  e_wr_data;
    logic [27:0] m_wr_data;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sxm_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rel(in_rel), .in_dst(in_dst), .in_a(in_a), .in_b(in_b),
        .in_imm(in_imm), .e_wr_en(e_wr_en), .e_wr_idx(e_wr_idx),
        .e_wr_data(e_wr_data), .m_wr_en(m_wr_en), .m_wr_idx(m_wr_idx),
        .m_wr_data(m_wr_data), .cond_valid(cond_valid), .cond(cond)
    );

    task automatic chk(input string name, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", name, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with the result visible
    task automatic issue(input op_e op, input logic [2:0] rel, input logic [2:0] d,
                         input logic [2:0] a, input logic [2:0] b, input logic [27:0] imm);
        in_valid = 1'b1; in_op = 4'(op); in_rel = rel;
        in_dst = d; in_a = a; in_b = b; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic eld(input logic [2:0] d, input logic [9:0] v);
        issue(OP_ELDI, 3'd0, d, 3'd0, 3'd0, {18'd0, v});
    endtask

    task automatic mld(input logic [2:0] d, input logic [27:0] v);
        issue(OP_MLDI, 3'd0, d, 3'd0, 3'd0, v);
    endtask

    task automatic t_reset();
        chk("R12 outputs in reset", {29'd0, e_wr_en, m_wr_en, cond_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(OP_FFO, 3'd0, 3'd1, 3'd7, 3'd0, '0);
        chk("R12 mantissa reg cleared", 32'(e_wr_data), 32'd27);
        issue(OP_ENEG, 3'd0, 3'd0, 3'd5, 3'd0, '0);
        chk("R12 exponent reg cleared", 32'(cond), 32'd0);
    endtask

    task automatic t_loads_idle();
        eld(3'd2, 10'h155);
        chk("R2 eldi en/idx", {28'd0, e_wr_en, e_wr_idx}, {28'd0, 1'b1, 3'd2});
        chk("R2 eldi data", 32'(e_wr_data), 32'h155);
        mld(3'd4, 28'hA123456);
        chk("R2 mldi data", 32'(m_wr_data), 32'hA123456);
        chk("R1 single output", {29'd0, e_wr_en, m_wr_en, cond_valid}, 32'b010);
        @(negedge clk);
        chk("R1 idle no output", {29'd0, e_wr_en, m_wr_en, cond_valid}, 32'd0);
        issue(op_e'(4'd14), 3'd0, 3'd4, 3'd4, 3'd4, 28'hFFFFFFF);
        chk("R1 unused opcode no output", {29'd0, e_wr_en, m_wr_en, cond_valid}, 32'd0);
        issue(OP_ABS, 3'd0, 3'd5, 3'd4, 3'd0, '0);
        chk("R1 unused opcode left M4", 32'(m_wr_data), 32'h2123456);
    endtask

    task automatic t_back_to_back();
        in_valid = 1'b1; in_op = 4'(OP_MLDI); in_dst = 3'd1; in_imm = 28'h2000000;
        @(negedge clk);
        chk("R1 first result visible", 32'(m_wr_data), 32'h2000000);
        in_op = 4'(OP_MADD); in_dst = 3'd2; in_a = 3'd1; in_b = 3'd1;
        @(negedge clk);
        chk("R1 dependent add uses new M1", 32'(m_wr_data), 32'h4000000);
        in_op = 4'(OP_ELDI); in_dst = 3'd3; in_imm = 28'd2;
        @(negedge clk);
        in_op = 4'(OP_SHR); in_dst = 3'd0; in_a = 3'd2; in_b = 3'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 dependent shift uses new E3", 32'(m_wr_data), 32'h1000000);
    endtask

    task automatic t_exp();
        eld(3'd0, 10'd300); eld(3'd1, 10'd300);
        issue(OP_EADD, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R3 add wraps", 32'(e_wr_data), 32'd600);
        eld(3'd0, 10'd5); eld(3'd1, 10'd9);
        issue(OP_ESUB, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R3 sub negative", 32'(e_wr_data), 32'h3FC);
        issue(OP_ENEG, 3'd0, 3'd0, 3'd2, 3'd0, '0);
        chk("R11 negative exponent", {30'd0, cond_valid, cond}, 32'b11);
        issue(OP_ENEG, 3'd0, 3'd0, 3'd0, 3'd0, '0);
        chk("R11 positive exponent", {30'd0, cond_valid, cond}, 32'b10);
    endtask

    task automatic t_ffo();
        mld(3'd0, 28'h2000000);
        issue(OP_FFO, 3'd0, 3'd1, 3'd0, 3'd0, '0);
        chk("R4 bit25", 32'(e_wr_data), 32'd1);
        mld(3'd0, 28'h8000001);
        issue(OP_FFO, 3'd0, 3'd1, 3'd0, 3'd0, '0);
        chk("R4 bit0 ignores sign", 32'(e_wr_data), 32'd26);
        mld(3'd0, 28'h8000000);
        issue(OP_FFO, 3'd0, 3'd1, 3'd0, 3'd0, '0);
        chk("R4 zero magnitude", 32'(e_wr_data), 32'd27);
    endtask

    task automatic t_addsub();
        mld(3'd0, 28'h4000000); mld(3'd1, 28'h2000000);
        issue(OP_MADD, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R5 add", 32'(m_wr_data), 32'h6000000);
        issue(OP_MSUB, 3'd0, 3'd2, 3'd1, 3'd0, '0);
        chk("R5 sub to negative", 32'(m_wr_data), 32'hA000000);
        issue(OP_MSUB, 3'd0, 3'd2, 3'd0, 3'd0, '0);
        chk("R5 equal sub is +0", 32'(m_wr_data), 32'h0);
        issue(OP_MADD, 3'd0, 3'd2, 3'd0, 3'd0, '0);
        chk("R5 carry dropped", 32'(m_wr_data), 32'h0);
        mld(3'd3, 28'h3000000); mld(3'd4, 28'h9000000);
        issue(OP_MADD, 3'd0, 3'd2, 3'd3, 3'd4, '0);
        chk("R5 mixed signs", 32'(m_wr_data), 32'h2000000);
    endtask

    task automatic t_mul();
        mld(3'd0, 28'hC000000); mld(3'd1, 28'h4000000);
        issue(OP_MMUL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R6 neg*pos", 32'(m_wr_data), 32'hA000000);
        mld(3'd0, 28'h6000000);
        issue(OP_MMUL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R6 0.75*0.5", 32'(m_wr_data), 32'h3000000);
        mld(3'd0, 28'h7FFFFFF);
        issue(OP_MMUL, 3'd0, 3'd2, 3'd0, 3'd0, '0);
        chk("R6 max*max top bit", 32'(m_wr_data), 32'h7FFFFFE);
    endtask

    task automatic t_shift();
        mld(3'd0, 28'h0100000);
        eld(3'd1, 10'd2);
        issue(OP_SHL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R7 left 2", 32'(m_wr_data), 32'h0400000);
        eld(3'd1, 10'h3FE);
        issue(OP_SHL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R7 left by -2", 32'(m_wr_data), 32'h0040000);
        mld(3'd0, 28'h8800000);
        eld(3'd1, 10'd3);
        issue(OP_SHR, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R7 right 3 keeps sign", 32'(m_wr_data), 32'h8100000);
        eld(3'd1, 10'h3FF);
        issue(OP_SHR, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R7 right by -1", 32'(m_wr_data), 32'h9000000);
        mld(3'd0, 28'h0000001);
        eld(3'd1, 10'd26);
        issue(OP_SHL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R8 count 26 still shifts", 32'(m_wr_data), 32'h4000000);
        eld(3'd1, 10'd27);
        issue(OP_SHL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R8 count 27 zero", 32'(m_wr_data), 32'h0);
        mld(3'd0, 28'h4000000);
        eld(3'd1, 10'h3E5);
        issue(OP_SHL, 3'd0, 3'd2, 3'd0, 3'd1, '0);
        chk("R8 count -27 zero", 32'(m_wr_data), 32'h0);
    endtask

    task automatic t_sign();
        mld(3'd0, 28'hA000000);
        issue(OP_ABS, 3'd0, 3'd1, 3'd0, 3'd0, '0);
        chk("R9 abs", 32'(m_wr_data), 32'h2000000);
        issue(OP_NEG, 3'd0, 3'd1, 3'd1, 3'd0, '0);
        chk("R9 neg", 32'(m_wr_data), 32'hA000000);
        issue(OP_NEG, 3'd0, 3'd1, 3'd0, 3'd0, '0);
        chk("R9 neg of negative", 32'(m_wr_data), 32'h2000000);
    endtask

    task automatic t_cmp();
        eld(3'd0, 10'd1); mld(3'd0, 28'h4000000);
        eld(3'd1, 10'd0); mld(3'd1, 28'h7000000);
        issue(OP_CMP, 3'd4, 3'd0, 3'd0, 3'd1, '0);
        chk("R10 pos exp wins GT", {30'd0, cond_valid, cond}, 32'b11);
        issue(OP_CMP, 3'd3, 3'd0, 3'd0, 3'd1, '0);
        chk("R10 pos LE false", {30'd0, cond_valid, cond}, 32'b10);
        mld(3'd0, 28'hC000000); mld(3'd1, 28'hF000000);
        issue(OP_CMP, 3'd2, 3'd0, 3'd0, 3'd1, '0);
        chk("R10 neg larger exp LT", {30'd0, cond_valid, cond}, 32'b11);
        eld(3'd2, 10'd7); mld(3'd2, 28'h8000000);
        issue(OP_CMP, 3'd4, 3'd0, 3'd2, 3'd1, '0);
        chk("R10 zero GT negative", {30'd0, cond_valid, cond}, 32'b11);
        eld(3'd3, 10'h200); mld(3'd3, 28'h0000000);
        issue(OP_CMP, 3'd0, 3'd0, 3'd2, 3'd3, '0);
        chk("R10 zeros EQ", {30'd0, cond_valid, cond}, 32'b11);
        issue(OP_CMP, 3'd5, 3'd0, 3'd0, 3'd0, '0);
        chk("R10 self GE", {30'd0, cond_valid, cond}, 32'b11);
        issue(OP_CMP, 3'd1, 3'd0, 3'd0, 3'd0, '0);
        chk("R10 self NE false", {30'd0, cond_valid, cond}, 32'b10);
        issue(OP_CMP, 3'd6, 3'd0, 3'd0, 3'd0, '0);
        chk("R10 code 6 false", {30'd0, cond_valid, cond}, 32'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_loads_idle();
        t_back_to_back();
        t_exp();
        t_ffo();
        t_addsub();
        t_mul();
        t_shift();
        t_sign();
        t_cmp();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule